// File: doc/BRIEF.md
# Half-Precision Pair Widener

This block takes one 32-bit word that carries two IEEE-754 binary16 numbers and returns the same two numbers as binary32 bit patterns, one per output word. The lower half of the input is the first number and the upper half is the second. Each lane splits its half-word into sign, exponent and mantissa. It then builds the wider pattern for the class of the input: zero, subnormal, normal, infinity or NaN.

The widening is exact. Every binary16 value, including each subnormal, can be written as a binary32 normal number or zero, so no rounding takes place. Subnormal inputs are renormalized: the position of the leading one in the mantissa sets the new exponent, and the bits below it move to the top of the 23-bit fraction. Each NaN becomes one fixed quiet pattern and its payload is dropped. Results appear one clock after the input, qualified by a valid flag.

Top module: `half_pair_widen`

## Requirements
- R1: Input bits [15:0] produce `res_lo` and input bits [31:16] produce `res_hi`. In each half, bit 15 is the sign, bits [14:10] are the exponent and bits [9:0] are the mantissa.
- R2: A half with exponent 0 and mantissa 0 gives a binary32 magnitude of zero.
- R3: A half with exponent 0 and nonzero mantissa m gives the exact value m·2^-24 as a normal binary32. If the leading one of m is at bit p, the biased exponent is p+103 and the fraction holds the bits below p, left-aligned in bits [22:0].
- R4: A half with exponent e in 1..30 gives binary32 exponent e+112 and fraction m·2^13.
- R5: A half with exponent 31 and mantissa 0 gives magnitude 0x7F800000 (infinity).
- R6: A half with exponent 31 and nonzero mantissa gives magnitude 0x7FFFFFFF, whatever the payload.
- R7: Output bit 31 equals bit 15 of the corresponding input half, in every class.
- R8: `res_valid` is `in_valid` delayed by exactly one clock, and the results shown with it come from the word sampled at that edge.
- R9: When `in_valid` is low at an edge, both result words keep their previous value.
- R10: While reset is asserted, `res_valid`, `res_lo` and `res_hi` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_word` as carrying a pair to convert |
| in_word | input | 32 | Two binary16 values, the first in the low half |
| res_valid | output | 1 | Marks the result words as new |
| res_lo | output | 32 | binary32 pattern of the low half |
| res_hi | output | 32 | binary32 pattern of the high half |

## Verification
The block has no parameters, so the bench builds it exactly as it ships. This makes the whole input space small enough to sweep. The low lane sees all 65536 binary16 patterns, and the high lane sees the same set in a scrambled order, so every subnormal leading-one position and every NaN payload reaches each lane. Idle cycles are mixed in with garbage on the data input to show that the result words hold.

// File: rtl/half_pair_widen.sv
module half_pair_widen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        res_valid,
  output logic [31:0] res_lo,
  output logic [31:0] res_hi
);

  function automatic logic [31:0] widen(input logic [15:0] h);
    logic [4:0]  ex;
    logic [9:0]  mt;
    logic [3:0]  lead;
    logic [23:0] aligned;
    logic [30:0] mag;
    ex   = h[14:10];
    mt   = h[9:0];
    lead = '0;
    for (int k = 0; k < 10; k++)
      if (mt[k]) lead = 4'(k);
    aligned = {14'b0, mt} << (5'd23 - {1'b0, lead});
    if (ex == 5'd0)
      mag = (mt == 10'd0) ? 31'd0 : {{4'd0, lead} + 8'd103, aligned[22:0]};
    else if (ex == 5'd31)
      mag = (mt == 10'd0) ? {8'hFF, 23'd0} : 31'h7FFF_FFFF;
    else
      mag = {{3'd0, ex} + 8'd112, mt, 13'd0};
    return {h[15], mag};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_lo <= widen(in_word[15:0]);
        res_hi <= widen(in_word[31:16]);
      end
    end
  end

endmodule

// File: rtl/half_pair_widen_chk.sv
module half_pair_widen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        res_valid,
  input logic [31:0] res_lo,
  input logic [31:0] res_hi
);

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_lo) && $stable(res_hi)));

  assert_sign_carried_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_lo[31] == $past(in_word[15]) && res_hi[31] == $past(in_word[31])));

  assert_nan_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(in_word[14:10]) == 5'd31 && $past(in_word[9:0]) != 10'd0)
      |-> res_lo[30:0] == 31'h7FFF_FFFF);

  assert_inf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(in_word[30:26]) == 5'd31 && $past(in_word[25:16]) == 10'd0)
      |-> res_hi[30:0] == 31'h7F80_0000);

  assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(in_word[14:0]) == 15'd0) |-> res_lo[30:0] == 31'd0);

  assert_normal_fraction_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(in_word[14:10]) != 5'd0 && $past(in_word[14:10]) != 5'd31)
      |-> (res_lo[22:13] == $past(in_word[9:0]) && res_lo[12:0] == 13'd0));

endmodule

bind half_pair_widen half_pair_widen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .res_valid(res_valid), .res_lo(res_lo), .res_hi(res_hi)
);

// File: tb/half_pair_widen_tb_top.sv
module half_pair_widen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        res_valid;
  logic [31:0] res_lo, res_hi;

  int n_checks = 0;
  int n_fails  = 0;
  bit [31:0] exp_lo = '0, exp_hi = '0;

  half_pair_widen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .res_valid(res_valid), .res_lo(res_lo), .res_hi(res_hi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit [31:0] model(bit [15:0] h);
    int e = int'(h[14:10]);
    int m = int'(h[9:0]);
    int shifts = 0;
    bit [31:0] r;
    if (e == 31) r = (m == 0) ? 32'h7F80_0000 : 32'h7FFF_FFFF;
    else if (e == 0 && m == 0) r = 32'h0;
    else if (e == 0) begin
      while (m < 1024) begin m = m * 2; shifts++; end
      r = (32'(113 - shifts) << 23) | (32'(m - 1024) << 13);
    end else r = (32'(e + 112) << 23) | (32'(m) << 13);
    if (h[15]) r[31] = 1'b1;
    return r;
  endfunction

  function automatic string tag_of(bit [15:0] h);
    if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R5,R7" : "R6,R7";
    if (h[14:10] == 5'd0)  return (h[9:0] == 0) ? "R2,R7" : "R3,R7";
    return "R4,R7";
  endfunction

  task automatic check32(string tag, bit [31:0] got, bit [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(bit v, bit [31:0] w);
    bit [15:0] a = w[15:0];
    bit [15:0] b = w[31:16];
    in_valid = v;
    in_word  = w;
    @(negedge clk);
    check32("R8 valid", {31'd0, res_valid}, {31'd0, v});
    if (v) begin
      exp_lo = model(a);
      exp_hi = model(b);
      check32($sformatf("lane0 R1 %s in=%h", tag_of(a), a), res_lo, exp_lo);
      check32($sformatf("lane1 R1 %s in=%h", tag_of(b), b), res_hi, exp_hi);
    end else begin
      check32("R9 hold lo", res_lo, exp_lo);
      check32("R9 hold hi", res_hi, exp_hi);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    in_word = 32'hFFFF_FFFF;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check32("R10 reset valid", {31'd0, res_valid}, 32'd0);
    check32("R10 reset lo", res_lo, 32'd0);
    check32("R10 reset hi", res_hi, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      bit [15:0] lo = 16'(i);
      bit [15:0] hi = 16'(i) ^ 16'hA5C3;
      if (i % 7 == 3) step(1'b0, {16'(i * 3), ~lo});
      step(1'b1, {hi, lo});
    end
    step(1'b0, 32'h7C01_FC00);
    step(1'b0, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule